// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 18-bit words between a write clock domain and a read clock domain. The two clocks may be unrelated or the same clock. Read and write pointers cross between the domains as Gray codes, each through a two-flop synchroniser. The block has two timing modes, chosen while reset is held. In standard mode a read strobe fetches the next word into the output register. In fall-through mode the oldest word moves into the output register by itself, so the output register adds one word of capacity.

Besides the empty and full indications, the block drives a half-full flag and two threshold flags. The almost-empty flag is computed in the read domain and the almost-full flag in the write domain. Their two thresholds sit in offset registers. The write port loads them while a load strobe is held. After reset both offsets take a default value that depends on the depth. An output enable forces the read data to zero.

Top module: `pflag_async_fifo`

## Requirements
- R1: Words come out on `rdata_o` in the order they were accepted. A word is accepted on a `wclk_i` rising edge when `wen_i` is 1, `load_i` is 0 and `full_o` is 0.
- R2: Standard mode (`fwft_i` = 0 during reset): a `rclk_i` edge with `ren_i` = 1 and `empty_o` = 0 puts the next word on `rdata_o`. A read strobe while `empty_o` = 1 leaves `rdata_o` unchanged.
- R3: Standard mode: `empty_o` is 1 when the read side's synchronised write count equals its read count. `full_o` is 1 when the write side holds 2^ADDR_W unread words, which means exactly 256 writes are accepted from empty at the default depth. Writes while full are dropped.
- R4: Fall-through mode (`fwft_i` = 1 during reset): the oldest word appears on `rdata_o` without a read strobe. `empty_o` = 0 marks a valid word on `rdata_o`. A `ren_i` edge consumes that word.
- R5: Fall-through mode: with no reads, `full_o` rises after 2^ADDR_W + 1 accepted writes (257 at the default depth).
- R6: While `load_i` = 1, each write-enabled `wclk_i` edge stores `wdata_i[11:0]` into an offset register instead of the FIFO. The first such edge loads the empty offset, the next loads the full offset, and later edges alternate. Any cycle with `load_i` = 0 makes the next load target the empty offset again.
- R7: `pae_n_o` is 0 exactly when the read-side word count is at or below the empty offset. The read-side word count is the synchronised writes minus the reads, plus one while the fall-through output register holds a word.
- R8: `paf_n_o` is 0 exactly when 2^ADDR_W minus the write-side word count is at or below the full offset.
- R9: `hf_o` is 1 exactly when the write-side word count exceeds 2^(ADDR_W-1).
- R10: While `oe_ni` = 1, `rdata_o` is all zeros. The FIFO contents and order are not affected.
- R11: After reset both offsets equal min(2^ADDR_W/8 - 1, 127), which is 31 at the default depth.
- R12: The mode is sampled only on `rclk_i` edges while `rst_ni` = 0. Changes on `fwft_i` after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fwft_i | input | 1 | Mode strap: 1 = fall-through, 0 = standard |
| wen_i | input | 1 | Write enable |
| load_i | input | 1 | Redirect writes to the offset registers |
| wdata_i | input | DATA_W | Write data |
| ren_i | input | 1 | Read enable |
| oe_ni | input | 1 | Output enable, active low |
| rdata_o | output | DATA_W | Read data |
| empty_o | output | 1 | Empty (standard) or output-not-ready (fall-through) |
| full_o | output | 1 | Full (standard) or input-not-ready (fall-through) |
| hf_o | output | 1 | More than half full |
| pae_n_o | output | 1 | Almost empty, active low |
| paf_n_o | output | 1 | Almost full, active low |

## Verification
A write becomes visible to `empty_o` and `pae_n_o` two read edges after the write edge. In fall-through mode the word reaches `rdata_o` on the third edge. A read becomes visible to `full_o`, `hf_o` and `paf_n_o` two write edges after the read edge. A read strobe changes `rdata_o` on the same edge. Both ports run from one clock. The reference model passes its write and read totals through a two-stage delay and applies each edge's inputs at the rising edge. It then compares every output at the following falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  // reset threshold: depth/8 - 1, capped at 127
  function automatic int unsigned dflt_offset(input int unsigned depth);
    int unsigned v;
    v = depth / 8;
    if (v == 0) return 0;
    v = v - 1;
    if (v > 127) v = 127;
    return v;
  endfunction

endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pflag_fifo_mem.sv
module pflag_fifo_mem #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/pflag_fifo_wr.sv
module pflag_fifo_wr
  import pflag_fifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 8,
  parameter int OW = 12
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW:0]   rgray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          hf_o,
  output logic          paf_n_o,
  output logic [OW-1:0] eoff_o
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CMPW  = (CW > OW) ? CW : OW;
  localparam logic [OW-1:0] DFLT = OW'(dflt_offset(DEPTH));

  logic [CW-1:0]   wbin_q, rbin, wcnt;
  logic [CMPW-1:0] free;
  logic [OW-1:0]   eoff_q, foff_q;
  ofs_sel_e        sel_q;

  always_comb begin
    rbin = rgray_i;
    for (int i = CW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_i[i];
  end

  assign wcnt    = wbin_q - rbin;
  assign full_o  = (wcnt == CW'(DEPTH));
  assign we_o    = wen_i && !load_i && !full_o;
  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wbin_q ^ (wbin_q >> 1);
  assign free    = CMPW'(DEPTH) - CMPW'(wcnt);
  assign paf_n_o = !(free <= CMPW'(foff_q));
  assign hf_o    = (wcnt > CW'(DEPTH / 2));
  assign eoff_o  = eoff_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) wbin_q <= '0;
    else         wbin_q <= wbin_q + CW'(we_o);
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoff_q <= DFLT;
      foff_q <= DFLT;
      sel_q  <= SEL_EMPTY;
    end else if (load_i) begin
      if (wen_i) begin
        if (sel_q == SEL_EMPTY) eoff_q <= wdata_i[OW-1:0];
        else                    foff_q <= wdata_i[OW-1:0];
        sel_q <= (sel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
      end
    end else begin
      sel_q <= SEL_EMPTY;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && wen_i) |=> $stable(wbin_q));

  assert_wr_bound_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wcnt <= CW'(DEPTH));

  assert_gray_step_R1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray_o ^ $past(wgray_o)));

  assert_offset_hold_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(eoff_q) && $stable(foff_q)));
endmodule

// File: rtl/pflag_fifo_rd.sv
module pflag_fifo_rd #(
  parameter int DW = 18,
  parameter int AW = 8,
  parameter int OW = 12
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          ren_i,
  input  logic [AW:0]   wgray_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [OW-1:0] eoff_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          pae_n_o
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CMPW  = ((CW > OW) ? CW : OW) + 1;

  logic            fwft_q, ov_q, mem_empty, pop;
  logic [CW-1:0]   rbin_q, wbin, mcnt;
  logic [DW-1:0]   dout_q;
  logic [CMPW-1:0] level;

  // mode strap is captured only while reset is held
  always_ff @(posedge rclk_i) begin
    if (!rst_ni) fwft_q <= fwft_i;
  end

  always_comb begin
    wbin = wgray_i;
    for (int i = CW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_i[i];
  end

  assign mcnt      = wbin - rbin_q;
  assign mem_empty = (mcnt == '0);
  assign pop       = fwft_q ? ((!ov_q || ren_i) && !mem_empty) : (ren_i && !mem_empty);
  assign raddr_o   = rbin_q[AW-1:0];
  assign rgray_o   = rbin_q ^ (rbin_q >> 1);
  assign dout_o    = dout_q;
  assign empty_o   = fwft_q ? !ov_q : mem_empty;
  assign level     = CMPW'(mcnt) + CMPW'(fwft_q && ov_q);
  assign pae_n_o   = !(level <= CMPW'(eoff_i));

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q <= '0;
      dout_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (pop) begin
        rbin_q <= rbin_q + 1'b1;
        dout_q <= rdata_i;
        ov_q   <= fwft_q;
      end else if (ren_i) begin
        ov_q   <= 1'b0;
      end
    end
  end

  assert_no_underflow_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_q && ren_i && empty_o) |=> $stable(dout_o));

  assert_or_hold_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_q && !empty_o && !ren_i) |=> (!empty_o && $stable(dout_o)));

  assert_rd_bound_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    mcnt <= CW'(DEPTH));

  assert_mode_hold_R12: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $stable(fwft_q));
endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 12
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              fwft_i,
  input  logic              wen_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              hf_o,
  output logic              pae_n_o,
  output logic              paf_n_o
);
  localparam int PW = ADDR_W + 1;

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] mem_rd, dout;
  logic [OFS_W-1:0]  eoff;

  pflag_fifo_wr #(.DW(DATA_W), .AW(ADDR_W), .OW(OFS_W)) u_wr (
    .wclk_i  (wclk_i),
    .rst_ni  (rst_ni),
    .wen_i   (wen_i),
    .load_i  (load_i),
    .wdata_i (wdata_i),
    .rgray_i (rgray_s),
    .we_o    (we),
    .waddr_o (waddr),
    .wgray_o (wgray),
    .full_o  (full_o),
    .hf_o    (hf_o),
    .paf_n_o (paf_n_o),
    .eoff_o  (eoff)
  );

  pflag_fifo_sync #(.W(PW)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  pflag_fifo_sync #(.W(PW)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  pflag_fifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rd)
  );

  pflag_fifo_rd #(.DW(DATA_W), .AW(ADDR_W), .OW(OFS_W)) u_rd (
    .rclk_i  (rclk_i),
    .rst_ni  (rst_ni),
    .fwft_i  (fwft_i),
    .ren_i   (ren_i),
    .wgray_i (wgray_s),
    .rdata_i (mem_rd),
    .eoff_i  (eoff),
    .raddr_o (raddr),
    .rgray_o (rgray),
    .dout_o  (dout),
    .empty_o (empty_o),
    .pae_n_o (pae_n_o)
  );

  assign rdata_o = oe_ni ? '0 : dout;
endmodule

// File: tb/sim_pflag_async_fifo.sv
module sim_pflag_async_fifo;
  localparam int DW = 18;
  localparam int AW = 8;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          fwft = 1'b0, wen = 1'b0, ld = 1'b0, ren = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] rdata;
  logic          empty, full, hf, pae_n, paf_n;

  pflag_async_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFS_W(12)) u0 (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .fwft_i(fwft),
    .wen_i(wen), .load_i(ld), .wdata_i(din), .ren_i(ren), .oe_ni(oe_n),
    .rdata_o(rdata), .empty_o(empty), .full_o(full), .hf_o(hf),
    .pae_n_o(pae_n), .paf_n_o(paf_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int W, R, wq1, wq2, rq1, rq2, eoff, foff, acc;
  bit ov, sel, fw;
  logic [DW-1:0] dq;
  logic [DW-1:0] stream[$];
  logic [DW-1:0] seq = 18'h1000;

  function automatic int dflt();
    int v = D / 8 - 1;
    return (v > 127) ? 127 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int r_old = R, w_old = W, mc = wq2 - R;
    bit wr_ok = wen && !ld && ((W - rq2) != D);
    if (ld) begin
      if (wen) begin
        if (!sel) eoff = int'(din[11:0]); else foff = int'(din[11:0]);
        sel = !sel;
      end
    end else sel = 0;
    if (fw) begin
      if ((!ov || ren) && mc > 0) begin dq = stream[R]; R++; ov = 1; end
      else if (ren && ov) ov = 0;
    end else if (ren && mc > 0) begin dq = stream[R]; R++; end
    wq2 = wq1; wq1 = w_old; rq2 = rq1; rq1 = r_old;
    if (wr_ok) begin stream.push_back(din); W++; end
  endtask

  task automatic compare();
    int wc = W - rq2;
    int rc = (wq2 - R) + ((fw && ov) ? 1 : 0);
    bit e_exp = fw ? !ov : ((wq2 - R) == 0);
    logic [DW-1:0] q_exp = oe_n ? '0 : dq;
    chk(rdata === q_exp, oe_n ? "R10 rdata gated" : "R1 rdata order", rdata, q_exp);
    chk(empty === e_exp, fw ? "R4 output-ready" : "R3 empty", empty, e_exp);
    chk(full === (wc == D), fw ? "R5 input-ready" : "R3 full", full, wc == D);
    chk(hf === (wc > D / 2), "R9 half", hf, wc > D / 2);
    chk(pae_n === !(rc <= eoff), "R7 almost-empty", pae_n, !(rc <= eoff));
    chk(paf_n === !((D - wc) <= foff), "R8 almost-full", paf_n, !((D - wc) <= foff));
  endtask

  task automatic cyc();
    if (wen && !ld && !full) acc++;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input bit mode);
    fwft = mode; rst_ni = 1'b0; wen = 0; ren = 0; ld = 0; oe_n = 0;
    repeat (3) @(posedge clk);
    W = 0; R = 0; wq1 = 0; wq2 = 0; rq1 = 0; rq2 = 0; ov = 0; sel = 0;
    dq = '0; eoff = dflt(); foff = dflt(); fw = mode; acc = 0;
    stream.delete();
    @(negedge clk);
    rst_ni = 1'b1;
    compare();
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      wen = 1; din = seq; seq = seq + 18'd7;
      cyc();
    end
    wen = 0;
  endtask

  task automatic pop(input int n);
    for (int i = 0; i < n; i++) begin ren = 1; cyc(); end
    ren = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic load_ofs(input int v);
    ld = 1; wen = 1; din = DW'(v); cyc(); wen = 0; ld = 0;
  endtask

  task automatic mixed(input int n);
    for (int i = 0; i < n; i++) begin
      wen = ($urandom % 3) != 0;
      ren = ($urandom % 2) != 0;
      oe_n = ($urandom % 8) == 0;
      din = seq; seq = seq + 18'd13;
      cyc();
    end
    wen = 0; ren = 0; oe_n = 0;
  endtask

  initial begin
    void'($urandom(32'd17));
    // standard mode
    do_reset(1'b0);
    chk(empty === 1'b1 && full === 1'b0 && hf === 1'b0, "R3 reset flags", {empty, full, hf}, 3'b100);
    chk(pae_n === 1'b0 && paf_n === 1'b1, "R11 default offsets at reset", {pae_n, paf_n}, 2'b01);
    pop(3);
    chk(rdata === '0, "R2 read while empty ignored", rdata, 0);
    push(40); idle(4); pop(10); idle(4);
    acc = 0; push(300); idle(4);
    chk(acc == D - 30, "R3 accepted writes until full", acc, D - 30);
    chk(full === 1'b1, "R3 full asserted", full, 1);
    pop(D + 5); idle(4);
    chk(empty === 1'b1, "R2 drained and extra reads ignored", empty, 1);
    // offset programming: empty, full, empty, then restart after load low
    ld = 1; wen = 1; din = 18'h3005; cyc(); din = 18'h300a; cyc(); din = 18'h3007; cyc();
    wen = 0; ld = 0; cyc();
    load_ofs(4); idle(3);
    chk(empty === 1'b1, "R6 offset writes not stored", empty, 1);
    push(4); idle(4);
    chk(pae_n === 1'b0, "R6 R7 empty offset reloaded to 4", pae_n, 0);
    push(1); idle(4);
    chk(pae_n === 1'b1, "R7 above empty offset", pae_n, 1);
    acc = 0; push(D); idle(4);
    chk(paf_n === 1'b0 && hf === 1'b1, "R8 R9 near full", {paf_n, hf}, 2'b01);
    oe_n = 1; idle(2);
    chk(rdata === '0, "R10 output disabled", rdata, 0);
    oe_n = 0; pop(D); idle(4);
    mixed(1500); pop(D + 4); idle(4);

    // fall-through mode
    do_reset(1'b1);
    fwft = 1'b0; // must be ignored after reset
    push(1); idle(5);
    chk(empty === 1'b0 && rdata === stream[0], "R4 R12 word falls through", rdata, stream[0]);
    pop(1); idle(3);
    chk(empty === 1'b1, "R4 word consumed", empty, 1);
    acc = 0; push(D + 10); idle(6);
    chk(acc == D + 1, "R5 capacity depth+1", acc, D + 1);
    pop(D + 3); idle(4);
    mixed(1500); pop(D + 4); idle(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule